// File: doc/BRIEF.md
# Width-Adapting Memory Marshaler

This block lets a client treat storage as an array of `ELEM_CNT` elements, each `ELEM_W` bits wide, while the storage behind it is a memory port with a fixed word width of `MEM_W` bits. Both sides use the same RAM-style, latency-insensitive protocol, with three channels that each carry a valid/ready handshake: a write channel, a read-request channel and a read-response channel. The client always exchanges data at its own element width, whatever the word size of the memory.

The geometry of the container is worked out at elaboration from the three parameters. When elements are narrower than a word, several elements share one word. A client write then turns into a read-modify-write: the block reads the word, replaces the element's slice and writes the word back. When elements are as wide as a word or wider, each element takes a run of consecutive words. A client access then turns into a group of single-word memory beats, issued in ascending order.

The block handles one client operation at a time. This keeps responses in request order and ensures that a read never overtakes an earlier write-back to memory.

Top module: `mem_marshaler`

## Requirements
- R1: Packed mode is chosen when `ELEM_W < MEM_W`. It holds K = floor(MEM_W/ELEM_W) elements per word and uses ceil(ELEM_CNT/K) words. Otherwise split mode is chosen, with B = ceil(ELEM_W/MEM_W) words per element and ELEM_CNT*B words. No memory address at or beyond the word count is ever issued.
- R2: In packed mode, element i lives in word i/K at bit slice [(i%K)*ELEM_W +: ELEM_W].
- R3: In packed mode, a client write issues exactly one memory read of the containing word, followed by exactly one memory write of the same word. That write changes only the element's slice and leaves every other bit of the word as it was read.
- R4: In split mode, a client write issues B memory writes to addresses i*B+b for b = 0..B-1, in ascending order. Beat b carries element bits [b*MEM_W +: MEM_W], and bits beyond the element width are zero.
- R5: In split mode, a client read issues B memory read requests to addresses i*B+b, in ascending order. The client response is raised only after the last beat has returned.
- R6: A client read returns the `ELEM_W`-bit value last written to that element, or the value already stored in memory if the element has not been written.
- R7: Only one client operation is in progress at a time. No memory request of a later operation appears before the last memory transfer of the earlier one, and read responses come back in request order.
- R8: When a write and a read request are both offered while the block is idle, the write is accepted first, and the read-request ready stays low in that cycle.
- R9: Every valid output (memory write, memory read request, client response) that is stalled by a low ready stays high with unchanged address and data until it is accepted.
- R10: After reset, the block is idle: write ready is high, and client response valid, memory write valid, memory read-request valid and memory response ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_wr_valid | input | 1 | Client write offered |
| cl_wr_ready | output | 1 | Client write accepted |
| cl_wr_idx | input | IW | Element index of the write |
| cl_wr_data | input | ELEM_W | Element value to write |
| cl_rq_valid | input | 1 | Client read request offered |
| cl_rq_ready | output | 1 | Client read request accepted |
| cl_rq_idx | input | IW | Element index to read |
| cl_rs_valid | output | 1 | Client read response present |
| cl_rs_ready | input | 1 | Client takes the response |
| cl_rs_data | output | ELEM_W | Element value read |
| mem_wr_valid | output | 1 | Memory word write offered |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Word address of the write |
| mem_wr_data | output | MEM_W | Word to write |
| mem_rq_valid | output | 1 | Memory read request offered |
| mem_rq_ready | input | 1 | Memory accepts the read request |
| mem_rq_addr | output | AW | Word address to read |
| mem_rs_valid | input | 1 | Memory read data present |
| mem_rs_ready | output | 1 | Block takes the read data |
| mem_rs_data | input | MEM_W | Word read from memory |

## Verification
The bench targets writes to two elements that share a word, and checks that the neighbour's bits survive the write. A design that merged into a stale or zeroed word would overwrite the neighbour. It reads back an element right after writing to the same word, which catches a design that lets the read request pass an unsent write-back and so returns the old value. In split mode it checks that the beat addresses ascend, that the last beat is zero-padded, and that the client response appears only after the final beat. A design that answered early would deliver a partly assembled element. It also offers a write and a read together, and applies random stalls on every channel so that any output which drifts while stalled is exposed.

// File: rtl/mrsh_pkg.sv
package mrsh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDREQ,
      ST_RDWAIT,
      ST_WRITE,
      ST_RESP
   } mrsh_state_e;

   function automatic int idx_bits(int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

   function automatic int elems_per_word(int mw, int ew);
      return (ew < mw) ? mw / ew : 1;
   endfunction

   function automatic int words_per_elem(int mw, int ew);
      return (ew < mw) ? 1 : (ew + mw - 1) / mw;
   endfunction

   function automatic int backing_words(int mw, int ew, int n);
      int k;
      k = elems_per_word(mw, ew);
      return (ew < mw) ? (n + k - 1) / k : n * words_per_elem(mw, ew);
   endfunction

endpackage

// File: rtl/mrsh_geom.sv
module mrsh_geom
   import mrsh_pkg::*;
#(
   parameter int MEM_W    = 32,
   parameter int ELEM_W   = 12,
   parameter int ELEM_CNT = 64,
   localparam int IW  = idx_bits(ELEM_CNT),
   localparam int BW  = idx_bits(words_per_elem(MEM_W, ELEM_W)),
   localparam int SW  = idx_bits(elems_per_word(MEM_W, ELEM_W)),
   localparam int AW  = idx_bits(backing_words(MEM_W, ELEM_W, ELEM_CNT))
) (
   input  logic [IW-1:0] idx_i,
   input  logic [BW-1:0] beat_i,
   output logic [AW-1:0] addr_o,
   output logic [SW-1:0] slot_o
);
   localparam int EPW = elems_per_word(MEM_W, ELEM_W);
   localparam int WPE = words_per_elem(MEM_W, ELEM_W);

   if (ELEM_W < MEM_W) begin : g_pack
      // word = index / elements-per-word, slot = remainder (beat is always zero here)
      assign addr_o = AW'(32'(idx_i) / EPW + 32'(beat_i));
      assign slot_o = SW'(32'(idx_i) % EPW);
   end else begin : g_split
      // consecutive words per element, beats ascending
      assign addr_o = AW'(32'(idx_i) * WPE + 32'(beat_i));
      assign slot_o = '0;
   end
endmodule

// File: rtl/mrsh_merge.sv
module mrsh_merge #(
   parameter int MEM_W  = 32,
   parameter int ELEM_W = 12,
   parameter int SW     = 1
) (
   input  logic [MEM_W-1:0]  word_i,
   input  logic [ELEM_W-1:0] elem_i,
   input  logic [SW-1:0]     slot_i,
   output logic [MEM_W-1:0]  word_o
);
   always_comb begin
      word_o = word_i;
      word_o[32'(slot_i)*ELEM_W +: ELEM_W] = elem_i;
   end
endmodule

// File: rtl/mem_marshaler.sv
module mem_marshaler
   import mrsh_pkg::*;
#(
   parameter int MEM_W    = 32,
   parameter int ELEM_W   = 12,
   parameter int ELEM_CNT = 64,
   localparam int IW = idx_bits(ELEM_CNT),
   localparam int AW = idx_bits(backing_words(MEM_W, ELEM_W, ELEM_CNT))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cl_wr_valid,
   output logic              cl_wr_ready,
   input  logic [IW-1:0]     cl_wr_idx,
   input  logic [ELEM_W-1:0] cl_wr_data,
   input  logic              cl_rq_valid,
   output logic              cl_rq_ready,
   input  logic [IW-1:0]     cl_rq_idx,
   output logic              cl_rs_valid,
   input  logic              cl_rs_ready,
   output logic [ELEM_W-1:0] cl_rs_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [AW-1:0]     mem_wr_addr,
   output logic [MEM_W-1:0]  mem_wr_data,
   output logic              mem_rq_valid,
   input  logic              mem_rq_ready,
   output logic [AW-1:0]     mem_rq_addr,
   input  logic              mem_rs_valid,
   output logic              mem_rs_ready,
   input  logic [MEM_W-1:0]  mem_rs_data
);
   localparam bit PACKED = (ELEM_W < MEM_W);
   localparam int EPW    = elems_per_word(MEM_W, ELEM_W);
   localparam int WPE    = words_per_elem(MEM_W, ELEM_W);
   localparam int WORDS  = backing_words(MEM_W, ELEM_W, ELEM_CNT);
   localparam int SW     = idx_bits(EPW);
   localparam int BW     = idx_bits(WPE);
   localparam int BUF_W  = WPE * MEM_W;

   if (MEM_W < 1 || ELEM_W < 1) begin : g_bad_width
      $error("mem_marshaler: widths must be positive");
   end
   if (ELEM_CNT < 2) begin : g_bad_count
      $error("mem_marshaler: ELEM_CNT must be at least 2");
   end

   mrsh_state_e      st_q;
   logic             op_wr_q;
   logic [IW-1:0]    idx_q;
   logic [BW-1:0]    beat_q;
   logic [BUF_W-1:0] buf_q;
   logic [AW-1:0]    addr_w;
   logic [SW-1:0]    slot_w;
   logic [MEM_W-1:0] merged_w;
   logic             last_beat;

   mrsh_geom #(
      .MEM_W    (MEM_W),
      .ELEM_W   (ELEM_W),
      .ELEM_CNT (ELEM_CNT)
   ) geom_i (
      .idx_i  (idx_q),
      .beat_i (beat_q),
      .addr_o (addr_w),
      .slot_o (slot_w)
   );

   if (PACKED) begin : g_rmw
      mrsh_merge #(
         .MEM_W  (MEM_W),
         .ELEM_W (ELEM_W),
         .SW     (SW)
      ) merge_i (
         .word_i (mem_rs_data),
         .elem_i (buf_q[ELEM_W-1:0]),
         .slot_i (slot_w),
         .word_o (merged_w)
      );
   end else begin : g_no_rmw
      assign merged_w = mem_rs_data;
   end

   assign last_beat    = (32'(beat_q) == 32'(WPE - 1));
   assign cl_wr_ready  = (st_q == ST_IDLE);
   assign cl_rq_ready  = (st_q == ST_IDLE) && !cl_wr_valid;
   assign cl_rs_valid  = (st_q == ST_RESP);
   assign cl_rs_data   = buf_q[32'(slot_w)*ELEM_W +: ELEM_W];
   assign mem_rq_valid = (st_q == ST_RDREQ);
   assign mem_rq_addr  = addr_w;
   assign mem_rs_ready = (st_q == ST_RDWAIT);
   assign mem_wr_valid = (st_q == ST_WRITE);
   assign mem_wr_addr  = addr_w;
   assign mem_wr_data  = buf_q[beat_q*MEM_W +: MEM_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_wr_q <= 1'b0;
         idx_q   <= '0;
         beat_q  <= '0;
         buf_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cl_wr_valid) begin
                  op_wr_q <= 1'b1;
                  idx_q   <= cl_wr_idx;
                  beat_q  <= '0;
                  buf_q   <= BUF_W'(cl_wr_data);
                  st_q    <= PACKED ? ST_RDREQ : ST_WRITE;
               end else if (cl_rq_valid) begin
                  op_wr_q <= 1'b0;
                  idx_q   <= cl_rq_idx;
                  beat_q  <= '0;
                  st_q    <= ST_RDREQ;
               end
            end
            ST_RDREQ: begin
               if (mem_rq_ready) st_q <= ST_RDWAIT;
            end
            ST_RDWAIT: begin
               if (mem_rs_valid) begin
                  if (op_wr_q) begin
                     buf_q[MEM_W-1:0] <= merged_w;
                     st_q             <= ST_WRITE;
                  end else begin
                     buf_q[beat_q*MEM_W +: MEM_W] <= mem_rs_data;
                     if (last_beat) begin
                        st_q <= ST_RESP;
                     end else begin
                        beat_q <= beat_q + BW'(1);
                        st_q   <= ST_RDREQ;
                     end
                  end
               end
            end
            ST_WRITE: begin
               if (mem_wr_ready) begin
                  if (last_beat) st_q <= ST_IDLE;
                  else           beat_q <= beat_q + BW'(1);
               end
            end
            ST_RESP: begin
               if (cl_rs_ready) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

   assert_rq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rq_valid && !mem_rq_ready |=> mem_rq_valid && $stable(mem_rq_addr));

   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cl_rs_valid && !cl_rs_ready |=> cl_rs_valid && $stable(cl_rs_data));

   assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rq_valid || mem_wr_valid) |-> 32'(addr_w) < 32'(WORDS));

   if (PACKED) begin : g_chk_pack
      assert_rmw_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mem_wr_valid) |-> $past(mem_rs_valid && mem_rs_ready));
   end else begin : g_chk_split
      assert_wr_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_wr_valid && $past(mem_wr_valid && mem_wr_ready))
            |-> 32'(mem_wr_addr) == 32'($past(mem_wr_addr)) + 1);
      assert_rd_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_rq_valid && $past(mem_rs_valid && mem_rs_ready))
            |-> 32'(mem_rq_addr) == 32'($past(mem_rq_addr)) + 1);
   end
endmodule

// File: tb/mem_marshaler_tb_top.sv
module mem_marshaler_tb_harness #(
   parameter int MW = 16,
   parameter int EW = 5,
   parameter int NE = 10,
   parameter int unsigned SEED = 32'h1234_5678
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_chk,
   output int   n_fail
);
   // expected geometry from R1
   localparam bit PK    = (EW < MW);
   localparam int EPW   = PK ? MW / EW : 1;
   localparam int WPE   = PK ? 1 : (EW + MW - 1) / MW;
   localparam int WORDS = PK ? (NE + EPW - 1) / EPW : NE * WPE;
   localparam int IW    = $clog2(NE);
   localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic          cl_wr_valid, cl_wr_ready, cl_rq_valid, cl_rq_ready;
   logic          cl_rs_valid, cl_rs_ready;
   logic [IW-1:0] cl_wr_idx, cl_rq_idx;
   logic [EW-1:0] cl_wr_data, cl_rs_data;
   logic          mem_wr_valid, mem_wr_ready, mem_rq_valid, mem_rq_ready;
   logic          mem_rs_valid, mem_rs_ready;
   logic [AW-1:0] mem_wr_addr, mem_rq_addr;
   logic [MW-1:0] mem_wr_data, mem_rs_data;

   mem_marshaler #(.MEM_W(MW), .ELEM_W(EW), .ELEM_CNT(NE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cl_wr_valid(cl_wr_valid), .cl_wr_ready(cl_wr_ready),
      .cl_wr_idx(cl_wr_idx), .cl_wr_data(cl_wr_data),
      .cl_rq_valid(cl_rq_valid), .cl_rq_ready(cl_rq_ready), .cl_rq_idx(cl_rq_idx),
      .cl_rs_valid(cl_rs_valid), .cl_rs_ready(cl_rs_ready), .cl_rs_data(cl_rs_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_rq_valid(mem_rq_valid), .mem_rq_ready(mem_rq_ready), .mem_rq_addr(mem_rq_addr),
      .mem_rs_valid(mem_rs_valid), .mem_rs_ready(mem_rs_ready), .mem_rs_data(mem_rs_data)
   );

   typedef struct packed {
      logic         wr;
      logic [31:0]  addr;
      logic [127:0] data;
      logic [7:0]   req;
   } exp_t;

   exp_t          exp_q[$];
   logic [EW-1:0] rsp_q[$];
   logic [127:0]  pend_q[$];
   logic [127:0]  mem[WORDS];
   logic [EW-1:0] gold[NE];
   int unsigned   rng;
   int unsigned   stim;
   logic          pv_wr, pv_rq, pv_rs;
   logic [127:0]  pv_wr_a, pv_wr_d, pv_rq_a, pv_rs_d;

   function automatic logic [127:0] mmask(int w);
      return (128'd1 << w) - 128'd1;
   endfunction

   function automatic logic [127:0] init_pat(int w);
      return ((128'(w) * 128'd40503 + 128'd23131) ^ (128'(w) << 7)) & mmask(MW);
   endfunction

   // R2/R3: word content = stored pattern with every element slot overlaid
   function automatic logic [127:0] exp_word(int w);
      logic [127:0] r;
      r = init_pat(w);
      for (int s = 0; s < EPW; s++) begin
         if (w * EPW + s < NE) begin
            r = (r & ~(mmask(EW) << (s * EW))) | (128'(gold[w * EPW + s]) << (s * EW));
         end
      end
      return r;
   endfunction

   task automatic chk(bit ok, int r, string what, logic [127:0] act, logic [127:0] exv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exv);
      end
   endtask

   task automatic push_write(int wi, logic [EW-1:0] wd);
      exp_t e;
      gold[wi] = wd;
      if (PK) begin
         e = '{wr: 1'b0, addr: 32'(wi / EPW), data: '0, req: 8'd2};         // R2 read of word
         exp_q.push_back(e);
         e = '{wr: 1'b1, addr: 32'(wi / EPW), data: exp_word(wi / EPW), req: 8'd3}; // R3
         exp_q.push_back(e);
      end else begin
         for (int b = 0; b < WPE; b++) begin                                 // R4 beats
            e = '{wr: 1'b1, addr: 32'(wi * WPE + b),
                  data: (128'(wd) >> (b * MW)) & mmask(MW), req: 8'd4};
            exp_q.push_back(e);
         end
      end
   endtask

   task automatic push_read(int ri);
      exp_t e;
      rsp_q.push_back(gold[ri]);
      if (PK) begin
         e = '{wr: 1'b0, addr: 32'(ri / EPW), data: '0, req: 8'd7};         // R7 after write-back
         exp_q.push_back(e);
      end else begin
         for (int b = 0; b < WPE; b++) begin                                 // R5 beats
            e = '{wr: 1'b0, addr: 32'(ri * WPE + b), data: '0, req: 8'd5};
            exp_q.push_back(e);
         end
      end
   endtask

   // memory model and monitor, compared every clock at the falling edge
   task automatic model_step();
      exp_t e;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      // R9: stalled outputs hold
      if (pv_wr) chk(mem_wr_valid && 128'(mem_wr_addr) == pv_wr_a && 128'(mem_wr_data) == pv_wr_d,
                     9, "stalled memory write changed", 128'(mem_wr_data), pv_wr_d);
      if (pv_rq) chk(mem_rq_valid && 128'(mem_rq_addr) == pv_rq_a,
                     9, "stalled read request changed", 128'(mem_rq_addr), pv_rq_a);
      if (pv_rs) chk(cl_rs_valid && 128'(cl_rs_data) == pv_rs_d,
                     9, "stalled response changed", 128'(cl_rs_data), pv_rs_d);
      mem_wr_ready = rng[0] | rng[1];
      mem_rq_ready = rng[2] | rng[3];
      cl_rs_ready  = rng[4] | rng[5];
      pv_wr = mem_wr_valid && !mem_wr_ready;
      pv_wr_a = 128'(mem_wr_addr); pv_wr_d = 128'(mem_wr_data);
      pv_rq = mem_rq_valid && !mem_rq_ready;
      pv_rq_a = 128'(mem_rq_addr);
      pv_rs = cl_rs_valid && !cl_rs_ready;
      pv_rs_d = 128'(cl_rs_data);
      if (mem_wr_valid && mem_wr_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, 7, "unexpected memory write", 128'(mem_wr_addr), 128'd0);
         end else begin
            e = exp_q.pop_front();
            chk(e.wr && 32'(mem_wr_addr) == e.addr, int'(e.req), "memory write address/kind",
                128'(mem_wr_addr), 128'(e.addr));
            chk(128'(mem_wr_data) == e.data, int'(e.req), "memory write data",
                128'(mem_wr_data), e.data);
         end
         if (32'(mem_wr_addr) < 32'(WORDS)) mem[int'(mem_wr_addr)] = 128'(mem_wr_data);
      end
      if (mem_rq_valid && mem_rq_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, 7, "unexpected memory read request", 128'(mem_rq_addr), 128'd0);
         end else begin
            e = exp_q.pop_front();
            chk(!e.wr && 32'(mem_rq_addr) == e.addr, int'(e.req), "memory read address/kind",
                128'(mem_rq_addr), 128'(e.addr));
         end
         pend_q.push_back((32'(mem_rq_addr) < 32'(WORDS)) ? mem[int'(mem_rq_addr)] : 128'd0);
      end
      mem_rs_valid = (pend_q.size() != 0) && (rng[6] | rng[7]);
      mem_rs_data  = (pend_q.size() != 0) ? MW'(pend_q[0]) : '0;
      if (mem_rs_valid && mem_rs_ready) void'(pend_q.pop_front());
      if (cl_rs_valid && cl_rs_ready) begin
         // R5: all beats done before the response
         chk(exp_q.size() == 0, 5, "response before memory transfers finished",
             128'(exp_q.size()), 128'd0);
         if (rsp_q.size() == 0) begin
            chk(1'b0, 7, "unexpected client response", 128'(cl_rs_data), 128'd0);
         end else begin
            chk(cl_rs_data == rsp_q[0], 6, "client read data", 128'(cl_rs_data), 128'(rsp_q[0]));
            void'(rsp_q.pop_front());
         end
      end
   endtask

   initial begin
      logic [127:0] acc;
      rng = SEED;
      pv_wr = 1'b0; pv_rq = 1'b0; pv_rs = 1'b0;
      pv_wr_a = '0; pv_wr_d = '0; pv_rq_a = '0; pv_rs_d = '0;
      for (int w = 0; w < WORDS; w++) mem[w] = init_pat(w);
      for (int i = 0; i < NE; i++) begin
         if (PK) begin
            gold[i] = EW'(init_pat(i / EPW) >> ((i % EPW) * EW));
         end else begin
            acc = '0;
            for (int b = 0; b < WPE; b++) acc = acc | (init_pat(i * WPE + b) << (b * MW));
            gold[i] = EW'(acc);
         end
      end
      mem_wr_ready = 1'b0; mem_rq_ready = 1'b0; mem_rs_valid = 1'b0;
      mem_rs_data = '0; cl_rs_ready = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) model_step();
      end
   end

   // offer a write and/or a read, holding each until accepted
   task automatic issue(bit dw, int wi, logic [EW-1:0] wd, bit dr, int ri);
      bit wp, rp;
      wp = dw; rp = dr;
      @(negedge clk);
      while (wp || rp) begin
         cl_wr_valid = wp; cl_wr_idx = IW'(wi); cl_wr_data = wd;
         cl_rq_valid = rp; cl_rq_idx = IW'(ri);
         #1;
         if (wp && rp && cl_wr_ready)   // R8
            chk(!cl_rq_ready, 8, "read accepted alongside write", 128'(cl_rq_ready), 128'd0);
         if (wp && cl_wr_ready) begin
            push_write(wi, wd); wp = 1'b0;
         end else if (rp && cl_rq_ready) begin
            push_read(ri); rp = 1'b0;
         end
         @(negedge clk);
      end
      cl_wr_valid = 1'b0; cl_rq_valid = 1'b0;
   endtask

   function automatic int unsigned nxt(int unsigned s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   initial begin
      n_chk = 0; n_fail = 0; done = 1'b0; stim = SEED ^ 32'h9E37_79B9;
      cl_wr_valid = 1'b0; cl_rq_valid = 1'b0; cl_wr_idx = '0; cl_rq_idx = '0; cl_wr_data = '0;
      wait (rst_n);
      @(negedge clk); #1;
      // R10: idle after reset
      chk(cl_wr_ready && !cl_rs_valid && !mem_wr_valid && !mem_rq_valid && !mem_rs_ready,
          10, "reset state", {124'd0, cl_rs_valid, mem_wr_valid, mem_rq_valid, mem_rs_ready}, 128'd0);
      // R6: untouched elements read their stored value; R1 ends of range
      issue(1'b0, 0, '0, 1'b1, 0);
      issue(1'b0, 0, '0, 1'b1, NE - 1);
      issue(1'b1, 0, EW'(128'h5A5A5A5A5A), 1'b0, 0);
      issue(1'b1, NE - 1, '1, 1'b0, 0);
      // R3: neighbouring slots keep their bits
      issue(1'b1, 1, EW'(128'h1), 1'b0, 0);
      issue(1'b0, 0, '0, 1'b1, 0);
      issue(1'b0, 0, '0, 1'b1, 1);
      // R7: read right after a write to the same word
      issue(1'b1, 2, EW'(128'h3C3C3C3C), 1'b0, 0);
      issue(1'b0, 0, '0, 1'b1, 2);
      // R8: write and read offered together
      issue(1'b1, 3, EW'(128'h0F0F0F0F), 1'b1, 3);
      issue(1'b1, 4, '0, 1'b1, NE - 1);
      // R4/R5/R6: random mix
      for (int k = 0; k < 80; k++) begin
         stim = nxt(stim);
         issue(stim[0], int'(stim[15:8]) % NE, EW'({stim, nxt(stim), nxt(stim + 1), stim}),
               stim[1] | ~stim[0], int'(stim[27:20]) % NE);
      end
      for (int g = 0; g < 4000 && (exp_q.size() != 0 || rsp_q.size() != 0); g++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && rsp_q.size() == 0, 7, "operations left outstanding",
          128'(exp_q.size() + rsp_q.size()), 128'd0);
      done = 1'b1;
   end
endmodule

module mem_marshaler_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic d_pk, d_sp;
   int   c_pk, f_pk, c_sp, f_sp;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // packed configuration: 3 elements per 16-bit word
   mem_marshaler_tb_harness #(.MW(16), .EW(5), .NE(10), .SEED(32'h1357_9BDF)) h_pk (
      .clk(clk), .rst_n(rst_n), .done(d_pk), .n_chk(c_pk), .n_fail(f_pk));

   // split configuration: 3 beats of 8 bits per 20-bit element
   mem_marshaler_tb_harness #(.MW(8), .EW(20), .NE(6), .SEED(32'h2468_ACE1)) h_sp (
      .clk(clk), .rst_n(rst_n), .done(d_sp), .n_chk(c_sp), .n_fail(f_sp));

   initial begin
      int wd_fail;
      wd_fail = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 100000 && !(d_pk === 1'b1 && d_sp === 1'b1); c++) @(negedge clk);
      if (!(d_pk === 1'b1 && d_sp === 1'b1)) begin
         wd_fail = 1;
         $display("FAIL R7 watchdog: actual not finished expected finished");
      end
      $display("[TB] %0d tests run, %0d failed", c_pk + c_sp + wd_fail, f_pk + f_sp + wd_fail);
      $finish;
   end
endmodule